// File: doc/BRIEF.md
# Multi-Source Wiper Position Register

This block holds the tap position of one digitally controlled resistor ladder and drives the switch that joins the wiper to that tap. It keeps a 6-bit position and turns it into a one-hot enable over 64 taps. A chip with several ladders uses one instance per ladder. The command decoder and the nonvolatile store sit outside the block. The block only sees update strobes and the data that goes with them.

Four sources can change the position:

- a serial write value;
- a parallel transfer from any one of four stored slots;
- single-tap step pulses, up or down;
- a recall of slot 0.

Slot 0 is also loaded on reset, which stands in for power-up. The position is volatile, so nothing is kept across reset except what slot 0 supplies. Both the position and the tap enable are registered and change on the same clock edge. The switch select is therefore free of glitches.

Top module: `wiper_pos_reg`

## Requirements
- R1: Once reset is released, exactly one bit of `tap_en` is set in every cycle.
- R2: The set bit of `tap_en` has the index `pos_q`, and the two outputs change on the same clock edge. Position 0 (bit 0) is the low-terminal tap and position 63 (bit 63) is the high-terminal tap.
- R3: When `wr_req` is high, `pos_q` takes `wr_data` at the next clock edge.
- R4: When `xfer_req` is high, `pos_q` takes slot `xfer_sel` at the next edge. Slot k occupies bits [6k+5:6k] of `slot_data`.
- R5: A step with `step_up`=1 raises `pos_q` by one, and at 63 it stays at 63.
- R6: A step with `step_up`=0 lowers `pos_q` by one, and at 0 it stays at 0.
- R7: While `rst` is high, and on any edge where `recall_req` is high, `pos_q` loads slot 0, which is `slot_data[5:0]`.
- R8: When several strobes arrive together, the winner is chosen in this order: recall, then transfer, then write, then step.
- R9: With no strobe high, `pos_q` and `tap_en` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads slot 0 |
| recall_req | input | 1 | Reload slot 0 |
| xfer_req | input | 1 | Load the slot chosen by xfer_sel |
| xfer_sel | input | 2 | Slot index for a transfer |
| wr_req | input | 1 | Load wr_data |
| wr_data | input | 6 | Serial write value |
| step_req | input | 1 | Move one tap |
| step_up | input | 1 | Step direction: 1 toward the high end, 0 toward the low end |
| slot_data | input | 24 | Four stored slots, slot k in bits [6k+5:6k] |
| pos_q | output | 6 | Current position, for readback |
| tap_en | output | 64 | One-hot tap switch enable |

## Verification
Directed sequences first drive the step path into both ends of the range. This separates saturation from wrap-around. Next, all strobes are raised together and then removed one at a time. This shows whether the priority order is right or whether a lower-ranked source leaks through. A long run of random strobes with random slot contents then mixes every source with every slot index, and every cycle compares both the position and the full 64-bit enable against a model. That catches a wrong slot slice, a decoder that is off by one, and a tap enable that lags the position.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Which update source wins in a given cycle.
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_XFER   = 3'd2,
    SRC_WRITE  = 3'd3,
    SRC_STEP   = 3'd4
  } wiper_src_e;

endpackage

// File: rtl/wiper_src_pick.sv
module wiper_src_pick
  import wiper_pkg::*;
(
  input  logic       recall_req,
  input  logic       xfer_req,
  input  logic       wr_req,
  input  logic       step_req,
  output wiper_src_e src
);

  // Fixed priority: recall > transfer > write > step.
  always_comb begin
    if (recall_req)    src = SRC_RECALL;
    else if (xfer_req) src = SRC_XFER;
    else if (wr_req)   src = SRC_WRITE;
    else if (step_req) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

endmodule

// File: rtl/wiper_next_calc.sv
module wiper_next_calc
  import wiper_pkg::*;
#(
  parameter int POS_W     = 6,
  parameter int NUM_SLOTS = 4,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  wiper_src_e               src,
  input  logic [POS_W-1:0]         cur_pos,
  input  logic [SEL_W-1:0]         xfer_sel,
  input  logic [POS_W-1:0]         wr_data,
  input  logic                     step_up,
  input  logic [NUM_SLOTS*POS_W-1:0] slot_data,
  output logic [POS_W-1:0]         slot0_val,
  output logic [POS_W-1:0]         xfer_val,
  output logic [POS_W-1:0]         next_pos
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] slot_arr [NUM_SLOTS];
  logic [POS_W-1:0] step_val;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_arr[k] = slot_data[k*POS_W +: POS_W];
  end

  assign slot0_val = slot_arr[0];
  assign xfer_val  = slot_arr[xfer_sel];

  // Saturating single-tap move.
  always_comb begin
    if (step_up) step_val = (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
    else         step_val = (cur_pos == POS_MIN) ? POS_MIN : cur_pos - 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: next_pos = slot0_val;
      SRC_XFER:   next_pos = xfer_val;
      SRC_WRITE:  next_pos = wr_data;
      SRC_STEP:   next_pos = step_val;
      default:    next_pos = cur_pos;
    endcase
  end

endmodule

// File: rtl/tap_onehot_reg.sv
module tap_onehot_reg #(
  parameter int POS_W  = 6,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] rst_pos,
  input  logic [POS_W-1:0] next_pos,
  output logic [TAPS-1:0]  tap_q
);

  // One flop per tap; each compares the incoming position with its own index.
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic [POS_W-1:0] IDX = POS_W'(i);
    always_ff @(posedge clk) begin
      if (rst) tap_q[i] <= (rst_pos == IDX);
      else     tap_q[i] <= (next_pos == IDX);
    end
  end

endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W     = 6,
  parameter int NUM_SLOTS = 4,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TAPS     = 1 << POS_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       recall_req,
  input  logic                       xfer_req,
  input  logic [SEL_W-1:0]           xfer_sel,
  input  logic                       wr_req,
  input  logic [POS_W-1:0]           wr_data,
  input  logic                       step_req,
  input  logic                       step_up,
  input  logic [NUM_SLOTS*POS_W-1:0] slot_data,
  output logic [POS_W-1:0]           pos_q,
  output logic [TAPS-1:0]            tap_en
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  wiper_src_e       src;
  logic [POS_W-1:0] next_pos;
  logic [POS_W-1:0] slot0_val;
  logic [POS_W-1:0] xfer_val;

  wiper_src_pick u_pick (
    .recall_req (recall_req),
    .xfer_req   (xfer_req),
    .wr_req     (wr_req),
    .step_req   (step_req),
    .src        (src)
  );

  wiper_next_calc #(.POS_W(POS_W), .NUM_SLOTS(NUM_SLOTS)) u_calc (
    .src       (src),
    .cur_pos   (pos_q),
    .xfer_sel  (xfer_sel),
    .wr_data   (wr_data),
    .step_up   (step_up),
    .slot_data (slot_data),
    .slot0_val (slot0_val),
    .xfer_val  (xfer_val),
    .next_pos  (next_pos)
  );

  // Position register; reset recalls slot 0.
  always_ff @(posedge clk) begin
    if (rst) pos_q <= slot0_val;
    else     pos_q <= next_pos;
  end

  tap_onehot_reg #(.POS_W(POS_W)) u_taps (
    .clk      (clk),
    .rst      (rst),
    .rst_pos  (slot0_val),
    .next_pos (next_pos),
    .tap_q    (tap_en)
  );

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_en) == 1); // R1

  AST_TAP_INDEX: assert property (@(posedge clk) disable iff (rst)
    tap_en[pos_q] == 1'b1); // R2

  AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> pos_q == $past(slot0_val)); // R7

  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !recall_req) |=> pos_q == $past(xfer_val)); // R4

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !xfer_req && !recall_req) |=> pos_q == $past(wr_data)); // R3

  AST_UP_SAT: assert property (@(posedge clk) disable iff (rst)
    (step_req && step_up && !wr_req && !xfer_req && !recall_req && pos_q == POS_MAX)
      |=> pos_q == POS_MAX); // R5

  AST_DOWN_SAT: assert property (@(posedge clk) disable iff (rst)
    (step_req && !step_up && !wr_req && !xfer_req && !recall_req && pos_q == '0)
      |=> pos_q == '0); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_req && !wr_req && !xfer_req && !recall_req) |=> $stable(pos_q)); // R9

endmodule

// File: tb/wiper_pos_reg_bench.sv
`timescale 1ns/1ps
module wiper_pos_reg_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        recall_req, xfer_req, wr_req, step_req, step_up;
  logic [1:0]  xfer_sel;
  logic [5:0]  wr_data;
  logic [23:0] slot_data;
  logic [5:0]  pos_q;
  logic [63:0] tap_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [5:0] exp_pos;

  always #4 clk = ~clk;

  wiper_pos_reg u_wiper_pos_reg (
    .clk(clk), .rst(rst), .recall_req(recall_req), .xfer_req(xfer_req),
    .xfer_sel(xfer_sel), .wr_req(wr_req), .wr_data(wr_data),
    .step_req(step_req), .step_up(step_up), .slot_data(slot_data),
    .pos_q(pos_q), .tap_en(tap_en)
  );

  function automatic logic [5:0] model_next(logic [5:0] cur, logic rc, logic xf,
      logic [1:0] sel, logic wr, logic [5:0] wd, logic st, logic up, logic [23:0] sl);
    if (rc)      return sl[5:0];
    else if (xf) return sl[sel*6 +: 6];
    else if (wr) return wd;
    else if (st) begin
      if (up) return (cur == 6'h3F) ? 6'h3F : cur + 6'd1;
      else    return (cur == 6'h00) ? 6'h00 : cur - 6'd1;
    end
    return cur;
  endfunction

  function automatic string tag_of(logic rc, logic xf, logic wr, logic st, logic up);
    int n = int'(rc) + int'(xf) + int'(wr) + int'(st);
    if (n > 1)   return "R8";
    if (rc)      return "R7";
    if (xf)      return "R4";
    if (wr)      return "R3";
    if (st)      return up ? "R5" : "R6";
    return "R9";
  endfunction

  task automatic check_outputs(string tag);
    total++;
    if (pos_q !== exp_pos) begin
      bad++;
      $display("FAIL %s pos_q actual=%0h expected=%0h", tag, pos_q, exp_pos);
    end
    total++;
    if (tap_en !== (64'd1 << exp_pos)) begin
      bad++;
      $display("FAIL %s/R1/R2 tap_en actual=%h expected=%h", tag, tap_en, 64'd1 << exp_pos);
    end
  endtask

  task automatic apply(logic rc, logic xf, logic [1:0] sel, logic wr,
                       logic [5:0] wd, logic st, logic up);
    recall_req = rc; xfer_req = xf; xfer_sel = sel; wr_req = wr;
    wr_data = wd; step_req = st; step_up = up;
    exp_pos = model_next(exp_pos, rc, xf, sel, wr, wd, st, up, slot_data);
    @(posedge clk); @(negedge clk);
    check_outputs(tag_of(rc, xf, wr, st, up));
    recall_req = 0; xfer_req = 0; wr_req = 0; step_req = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; recall_req = 0; xfer_req = 0; wr_req = 0; step_req = 0;
    step_up = 0; xfer_sel = 0; wr_data = 0;
    slot_data = {6'h05, 6'h31, 6'h17, 6'h2A};
    @(negedge clk); @(negedge clk);
    rst = 0;
    exp_pos = 6'h2A;
    check_outputs("R7");                       // reset recall of slot 0

    // R3 write, R5 saturation at top
    apply(0,0,0,1,6'h3E,0,0);
    apply(0,0,0,0,0,1,1);
    apply(0,0,0,0,0,1,1);                      // R5 stays at 63
    apply(0,0,0,0,0,0,0);                      // R9 idle hold
    // R6 saturation at bottom
    apply(0,0,0,1,6'h01,0,0);
    apply(0,0,0,0,0,1,0);
    apply(0,0,0,0,0,1,0);                      // R6 stays at 0
    // R4 each slot
    for (int k = 0; k < 4; k++) apply(0,1,k[1:0],0,0,0,0);
    // R8 priority peeling
    apply(1,1,2'd2,1,6'h11,1,1);
    apply(0,1,2'd2,1,6'h11,1,1);
    apply(0,0,2'd2,1,6'h11,1,1);
    apply(0,0,0,0,0,1,1);
    // R7 recall after new slot 0
    slot_data[5:0] = 6'h09;
    apply(1,0,0,0,0,0,0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) slot_data = {$urandom} [23:0];
      apply(r[4] & r[5] & r[6], r[7] & r[8], r[10:9], r[11] & r[12],
            6'($urandom), r[13] | r[14], r[15]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule